// File: doc/BRIEF.md
# Four-Digit Multiplexed Seven-Segment Scanner

This block drives a common-anode seven-segment display of several digits that share one set of segment lines. It receives one decimal value per digit and a one-cycle scan pulse from a rate divider elsewhere. On each pulse a small phase counter steps forward. The phase chooses which digit position is lit and which digit value goes through the one segment lookup. Every digit gets two phases. In the first phase its anode is on. In the second phase all anodes are off, so that slow anode driver transistors can turn fully off before the next position lights. This removes ghost images on the display.

Anode and segment outputs both come from registers, so they always change on the same clock edge. Digit values above 9 show a dark position. Producing the digit values, the scan rate and any brightness control are left to the blocks around it.

Top module: `seg_scan_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase counter returns to 0 and the next outputs are `anode_n_o` = all ones and `seg_n_o` = 8'hFF.
- R2: The phase counter steps by one only at an edge where `scan_tick` is high. At any other edge it holds its value, and so do the outputs.
- R3: The phase counter runs from 0 to 2*NUM_DIGITS-1 (0 to 7 by default) and wraps back to 0. The digit in use is phase/2, where digit k is `digits_i[4k+3:4k]`.
- R4: In an even phase, exactly one anode is driven low: bit k of `anode_n_o` for digit k. Digit 0 gives 4'b1110 and digit 3 gives 4'b0111.
- R5: In an odd phase, every bit of `anode_n_o` is high.
- R6: No more than one bit of `anode_n_o` is low in any cycle.
- R7: Segments are active low, with bit 0 = a through bit 6 = g, and bit 7 = decimal point, which is always high. The codes for 0..9 are C0, F9, A4, B0, 99, 92, 82, F8, 80 and 90 (hex).
- R8: A digit value from 10 to 15 decodes to 8'hFF, which turns all segments off.
- R9: The outputs after an edge come from the phase and digit values that were present before that edge. Anode and segments change together, one cycle after the phase they show.
- R10: During the blank (odd) phase, `seg_n_o` still carries the code of the digit paired with that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_tick | input | 1 | One-cycle pulse that advances the scan phase |
| digits_i | input | NUM_DIGITS*DIGIT_W | Packed digit values, digit 0 in the low bits |
| anode_n_o | output | NUM_DIGITS | Active-low anode enables, bit k for digit k |
| seg_n_o | output | 8 | Active-low segments, bit 7 decimal point |

## Verification
The scan is first run with a tick on every cycle and four different digit values. This shows whether each anode is paired with the right digit, and whether the enabled and blank phases alternate and wrap correctly. A second run uses sparse ticks while the digit values sweep through 0..9. This separates an advance on the tick from an advance on the clock, and checks every segment code, including a digit that changes during its own blank phase. A third run uses digit values 10 to 15 to check the dark code. A long stretch with no tick, and a reset in the middle of the scan, check the hold behaviour and the return to phase 0.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
    localparam int unsigned SEG_W   = 8;
    localparam int unsigned DP_BIT  = 7;
    typedef logic [SEG_W-1:0] seg_t;
    localparam seg_t SEG_DARK = '1;
endpackage

// File: rtl/seg_phase_step.sv
module seg_phase_step #(
    parameter int unsigned PHASES = 8,
    localparam int unsigned PH_W  = $clog2(PHASES)
) (
    input  logic [PH_W-1:0] phase_i,
    input  logic            tick_i,
    output logic [PH_W-1:0] phase_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    always_comb begin
        phase_o = phase_i;
        if (tick_i) begin
            if (phase_i == LAST) phase_o = '0;
            else                 phase_o = phase_i + PH_W'(1);
        end
    end
endmodule

// File: rtl/seg_digit_pick.sv
module seg_digit_pick #(
    parameter int unsigned NUM_DIGITS = 4,
    parameter int unsigned DIGIT_W    = 4,
    localparam int unsigned PH_W      = $clog2(2 * NUM_DIGITS),
    localparam int unsigned IDX_W     = PH_W - 1
) (
    input  logic [PH_W-1:0]               phase_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
    output logic [DIGIT_W-1:0]            digit_o,
    output logic [NUM_DIGITS-1:0]         anode_n_o
);
    logic [IDX_W-1:0] idx;
    logic             blank;

    assign idx   = phase_i[PH_W-1:1];
    assign blank = phase_i[0];

    always_comb begin
        digit_o = '0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (idx == IDX_W'(k)) digit_o = digits_i[k*DIGIT_W +: DIGIT_W];
        end
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_anode
        localparam logic [IDX_W-1:0] POS = IDX_W'(g);
        assign anode_n_o[g] = !((idx == POS) && !blank);
    end
endmodule

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
    import seg_scan_pkg::*;
#(
    parameter int unsigned DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] digit_i,
    output seg_t               seg_n_o
);
    always_comb begin
        case (int'(digit_i))
            0:       seg_n_o = 8'hC0;
            1:       seg_n_o = 8'hF9;
            2:       seg_n_o = 8'hA4;
            3:       seg_n_o = 8'hB0;
            4:       seg_n_o = 8'h99;
            5:       seg_n_o = 8'h92;
            6:       seg_n_o = 8'h82;
            7:       seg_n_o = 8'hF8;
            8:       seg_n_o = 8'h80;
            9:       seg_n_o = 8'h90;
            default: seg_n_o = SEG_DARK;
        endcase
    end
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
    import seg_scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 4,
    parameter int unsigned DIGIT_W    = 4,
    localparam int unsigned PHASES    = 2 * NUM_DIGITS,
    localparam int unsigned PH_W      = $clog2(PHASES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scan_tick,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
    output logic [NUM_DIGITS-1:0]         anode_n_o,
    output logic [SEG_W-1:0]              seg_n_o
);
    typedef struct packed {
        logic [PH_W-1:0]       phase;
        logic [NUM_DIGITS-1:0] anode_n;
        seg_t                  seg_n;
    } scan_st_t;

    scan_st_t st_d, st_q;

    logic [PH_W-1:0]       phase_q;
    logic [PH_W-1:0]       phase_nx;
    logic [DIGIT_W-1:0]    cur_digit;
    logic [NUM_DIGITS-1:0] cur_anode_n;
    seg_t                  cur_seg_n;

    assign phase_q = st_q.phase;

    seg_phase_step #(.PHASES(PHASES)) u_step (
        .phase_i (phase_q),
        .tick_i  (scan_tick),
        .phase_o (phase_nx)
    );

    seg_digit_pick #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_pick (
        .phase_i   (phase_q),
        .digits_i  (digits_i),
        .digit_o   (cur_digit),
        .anode_n_o (cur_anode_n)
    );

    seg_glyph_rom #(.DIGIT_W(DIGIT_W)) u_rom (
        .digit_i (cur_digit),
        .seg_n_o (cur_seg_n)
    );

    always_comb begin
        st_d         = st_q;
        st_d.phase   = phase_nx;
        st_d.anode_n = cur_anode_n;
        st_d.seg_n   = cur_seg_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase   <= '0;
            st_q.anode_n <= '1;
            st_q.seg_n   <= SEG_DARK;
        end else begin
            st_q <= st_d;
        end
    end

    assign anode_n_o = st_q.anode_n;
    assign seg_n_o   = st_q.seg_n;
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
    parameter int unsigned NUM_DIGITS = 4,
    parameter int unsigned PH_W       = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scan_tick,
    input logic [PH_W-1:0]       phase_q,
    input logic [NUM_DIGITS-1:0] anode_n_o,
    input logic [7:0]            seg_n_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(2 * NUM_DIGITS - 1);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (anode_n_o == '1 && phase_q == '0 && seg_n_o == 8'hFF));

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !scan_tick |=> $stable(phase_q));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (scan_tick && phase_q == LAST) |=> (phase_q == '0));

    p_one_lit_r4: assert property (@(posedge clk) disable iff (rst)
        !phase_q[0] |=> ($countones(~anode_n_o) == 1));

    p_blank_r5: assert property (@(posedge clk) disable iff (rst)
        phase_q[0] |=> (anode_n_o == '1));

    p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~anode_n_o));

    p_dp_off_r7: assert property (@(posedge clk) disable iff (rst)
        seg_n_o[7]);
endmodule

bind seg_scan_top seg_scan_chk #(.NUM_DIGITS(NUM_DIGITS), .PH_W(PH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_tick (scan_tick),
    .phase_q   (phase_q),
    .anode_n_o (anode_n_o),
    .seg_n_o   (seg_n_o)
);

// File: tb/test_seg_scan_top.sv
module test_seg_scan_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_tick = 1'b0;
    logic [15:0] digits = 16'h0000;
    logic [3:0]  anode_n;
    logic [7:0]  seg_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    seg_scan_top i_seg_scan_top (
        .clk       (clk),
        .rst       (rst),
        .scan_tick (scan_tick),
        .digits_i  (digits),
        .anode_n_o (anode_n),
        .seg_n_o   (seg_n)
    );

    function automatic logic [7:0] glyph(int v);
        case (v)
            0: return 8'hC0;  1: return 8'hF9;  2: return 8'hA4;
            3: return 8'hB0;  4: return 8'h99;  5: return 8'h92;
            6: return 8'h82;  7: return 8'hF8;  8: return 8'h80;
            9: return 8'h90;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // reference model
    int         m_ph = 0;
    int         m_disp_ph = 0;
    int         m_dv = 0;
    bit         m_rst = 1;
    bit         m_wrapped = 0;
    logic [3:0] m_an = 4'hF;
    logic [7:0] m_seg = 8'hFF;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_an = 4'hF; m_seg = 8'hFF; m_rst = 1; m_wrapped = 0;
        end else begin
            int k;
            k = m_ph / 2;
            m_dv = int'((digits >> (4 * k)) & 16'hF);
            m_an = (m_ph % 2 == 1) ? 4'hF : ~(4'(1) << k);
            m_seg = glyph(m_dv);
            m_disp_ph = m_ph;
            m_rst = 0;
            if (scan_tick) begin
                if (m_ph == 7) m_wrapped = 1;
                m_ph = (m_ph + 1) % 8;
            end
        end
    end

    always @(posedge clk) begin
        #5;
        if (!done) begin
            if (m_rst) begin
                check(anode_n == m_an && seg_n == m_seg, "R1", {anode_n, seg_n}, {m_an, m_seg});
            end else begin
                if (m_disp_ph == 0 && m_wrapped)
                    check(anode_n == m_an, "R3", anode_n, m_an);
                else if (m_disp_ph % 2 == 1)
                    check(anode_n == m_an, "R5", anode_n, m_an);
                else
                    check(anode_n == m_an, "R4", anode_n, m_an);
                if (m_dv > 9)
                    check(seg_n == m_seg, "R8", seg_n, m_seg);
                else if (m_disp_ph % 2 == 1)
                    check(seg_n == m_seg, "R10", seg_n, m_seg);
                else
                    check(seg_n == m_seg, "R7", seg_n, m_seg);
            end
            check($countones(~anode_n) <= 1, "R6", anode_n, 4'hF);
        end
    end

    task automatic run(int cycles, int every, bit sweep);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            scan_tick = (every > 0) && (i % every == 0);
            if (sweep && (i % 3 == 0))
                digits = {4'((i / 3 + 3) % 10), 4'((i / 3 + 2) % 10),
                          4'((i / 3 + 1) % 10), 4'((i / 3) % 10)};
        end
        @(negedge clk);
        scan_tick = 1'b0;
    endtask

    initial begin
        logic [3:0] held_an;
        logic [7:0] held_seg;
        repeat (3) @(negedge clk);
        digits = 16'h4321;
        rst = 1'b0;
        @(posedge clk); #5;
        // R9: first edge out of reset shows phase 0 on both outputs
        check(anode_n == 4'b1110 && seg_n == 8'hA4 ? 1'b0 : 1'b1, "R9", 0, 0);
        check(anode_n == 4'b1110 && seg_n == 8'hF9, "R9", {anode_n, seg_n}, {4'b1110, 8'hF9});

        run(40, 1, 0);
        run(200, 5, 1);
        digits = 16'hFCBA;
        run(40, 1, 0);
        digits = 16'hD9E0;
        run(40, 2, 0);

        // R2: no tick for a long stretch, outputs frozen
        digits = 16'h7654;
        @(negedge clk);
        held_an = anode_n;
        held_seg = seg_n;
        repeat (20) @(negedge clk);
        check(anode_n == held_an && seg_n == held_seg, "R2", {anode_n, seg_n}, {held_an, held_seg});

        run(7, 1, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(anode_n == 4'hF && seg_n == 8'hFF, "R1", {anode_n, seg_n}, 12'hFFF);
        rst = 1'b0;
        run(30, 1, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule